// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block turns a six-channel drive command into gate requests for the high-side and low-side switches of six half-bridge outputs. Each channel has an enable bit and a side-select bit from the command register. The first two channels can also be switched by an external pulse-width input, which is ORed with the enable bit. A channel with both switches off is taken as high impedance.

The block enforces break-before-make inside every channel. Whenever a switch turns off, both switches of that channel stay off for a set number of system clocks before either may turn on again. This covers the change from one side to the other, and also a fast off-then-on of the same side. A level-sensitive shutdown input for each channel and a global supply-lockout input force switches off within one clock. The command bits are left untouched, so the programmed state comes back on its own once the blocking condition goes away. The external pulse inputs pass through a two-stage synchroniser first.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, every `hs_on` and `ls_on` bit is 0, and a channel first enabled from that state turns on one clock after the command is applied.
- R2: When channel i is effectively enabled and not blocked, `drv_cfg[i]`=0 drives `ls_on[i]`=1 and `hs_on[i]`=0, and `drv_cfg[i]`=1 drives `hs_on[i]`=1 and `ls_on[i]`=0. From idle the output follows one clock after the inputs.
- R3: For channels 0 and 1, the effective enable is `drv_en[i]` OR the synchronised `pwm_in[i]`. A rise on `pwm_in[i]` turns the channel on at the third rising clock edge.
- R4: Channels 2 to 5 do not respond to `pwm_in`. With their enable bit at 0 they stay off whatever the pulse inputs do.
- R5: With `drv_cfg[0]`=1 and `drv_en[0]`=0, `pwm_in[0]` alone switches `hs_on[0]` on and off, and `ls_on[0]` stays 0.
- R6: `hs_on[i]` and `ls_on[i]` are never 1 in the same cycle.
- R7: When a channel changes from one side to the other, both switches are off for exactly DEAD_CLKS clocks (default 8) between the old side going off and the new side coming on.
- R8: After any switch of a channel turns off, neither switch of that channel turns on for at least DEAD_CLKS clocks. This holds even when the same side is re-enabled at once, or a shutdown lands during the gap.
- R9: `supply_lock`=1 forces all switches off one clock later. When it is released after the gap has elapsed, the programmed states return one clock later without being rewritten.
- R10: `ch_fault[i]`=1 forces both switches of channel i off one clock later, leaves the other channels unchanged, and the channel resumes its programmed state once the fault input clears.
- R11: When the effective enable of a channel is 0, both of its switches are off one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_en | input | 6 | Per-channel enable bits from the command register |
| drv_cfg | input | 6 | Per-channel side select: 0 low side, 1 high side |
| pwm_in | input | 2 | Asynchronous pulse inputs for channels 0 and 1 |
| ch_fault | input | 6 | Latched per-channel shutdown, active high |
| supply_lock | input | 1 | Global supply lockout, active high |
| hs_on | output | 6 | High-side switch on request per channel |
| ls_on | output | 6 | Low-side switch on request per channel |

## Verification
Two events can land on the same clock edge: a side change that starts a dead-time gap, and a shutdown (channel fault or supply lockout) that blocks the new side. The bench flips the side-select bit and raises the fault in the same cycle. It checks that the gap still runs its full length, that no switch comes on when the gap ends while the fault is held, and that clearing the fault afterwards turns on the new side one clock later. The same gap count is measured for a plain side change and for an immediate off-then-on of one side, and each result is compared with DEAD_CLKS.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Per-channel driver mode
    typedef enum logic [1:0] {
        HB_IDLE = 2'd0,   // both off, gap already served
        HB_LOW  = 2'd1,   // low side conducting
        HB_HIGH = 2'd2,   // high side conducting
        HB_GAP  = 2'd3    // both off, dead time running
    } hb_mode_e;

    // Requested side after enable/shutdown qualification
    typedef enum logic [1:0] {
        WANT_NONE = 2'd0,
        WANT_LOW  = 2'd1,
        WANT_HIGH = 2'd2
    } hb_want_e;

endpackage

// File: rtl/hb_pwm_sync.sv
module hb_pwm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stg[k] = s_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stg[STAGES-1];

endmodule

// File: rtl/hb_demand.sv
module hb_demand #(
    parameter int NCH  = 6,
    parameter int NPWM = 2
) (
    input  logic [NCH-1:0]  drv_en,
    input  logic [NPWM-1:0] pwm_s,
    input  logic [NCH-1:0]  ch_fault,
    input  logic            supply_lock,
    output logic [NCH-1:0]  en_eff,
    output logic [NCH-1:0]  kill
);

    // Channels with a pulse input OR it into the enable; the rest use the bit alone
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i < NPWM) begin : g_pwm
            assign en_eff[i] = drv_en[i] | pwm_s[i];
        end else begin : g_plain
            assign en_eff[i] = drv_en[i];
        end
        assign kill[i] = ch_fault[i] | supply_lock;
    end

endmodule

// File: rtl/hb_channel.sv
module hb_channel #(
    parameter int DEAD_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_eff,
    input  logic cfg_high,
    input  logic kill,
    output logic hs_on,
    output logic ls_on
);
    import hb_pkg::*;

    localparam int CW = (DEAD_CLKS < 2) ? 1 : $clog2(DEAD_CLKS);
    localparam logic [CW-1:0] GAP_LOAD = CW'(DEAD_CLKS - 1);

    typedef struct packed {
        hb_mode_e        mode;
        logic [CW-1:0]   cnt;
    } chan_t;

    chan_t    s_d, s_q;
    hb_want_e want;

    always_comb begin
        if (kill || !en_eff) want = WANT_NONE;
        else if (cfg_high)   want = WANT_HIGH;
        else                 want = WANT_LOW;
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            HB_IDLE: begin
                if (want == WANT_HIGH)     s_d.mode = HB_HIGH;
                else if (want == WANT_LOW) s_d.mode = HB_LOW;
            end
            HB_LOW: begin
                if (want != WANT_LOW) begin
                    s_d.mode = HB_GAP;
                    s_d.cnt  = GAP_LOAD;
                end
            end
            HB_HIGH: begin
                if (want != WANT_HIGH) begin
                    s_d.mode = HB_GAP;
                    s_d.cnt  = GAP_LOAD;
                end
            end
            HB_GAP: begin
                if (s_q.cnt == '0) begin
                    if (want == WANT_HIGH)     s_d.mode = HB_HIGH;
                    else if (want == WANT_LOW) s_d.mode = HB_LOW;
                    else                       s_d.mode = HB_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.mode = HB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= HB_IDLE;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_on = (s_q.mode == HB_HIGH);
    assign ls_on = (s_q.mode == HB_LOW);

    // Checker support: clocks since both switches were last off, saturating
    localparam int OW = $clog2(DEAD_CLKS + 2);
    logic          drv_any;
    logic [OW-1:0] off_cnt_q;
    assign drv_any = hs_on | ls_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           off_cnt_q <= OW'(DEAD_CLKS);
        else if (drv_any)                     off_cnt_q <= '0;
        else if (off_cnt_q < OW'(DEAD_CLKS))  off_cnt_q <= off_cnt_q + 1'b1;
    end

    // R6: never both sides on
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R8: a turn-on only after a full off gap
    a_r8_gap_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_any) |-> (off_cnt_q >= OW'(DEAD_CLKS)));

    // R10: shutdown forces the channel off on the next clock
    a_r10_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!hs_on && !ls_on));

    // R11: no effective enable, nothing on
    a_r11_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> (!hs_on && !ls_on));

    // R2: high side only rises when the high side was requested
    a_r2_high_matches_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(cfg_high && en_eff && !kill));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
    parameter int NCH       = 6,
    parameter int NPWM      = 2,
    parameter int DEAD_CLKS = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  drv_en,
    input  logic [NCH-1:0]  drv_cfg,
    input  logic [NPWM-1:0] pwm_in,
    input  logic [NCH-1:0]  ch_fault,
    input  logic            supply_lock,
    output logic [NCH-1:0]  hs_on,
    output logic [NCH-1:0]  ls_on
);

    logic [NPWM-1:0] pwm_s;
    logic [NCH-1:0]  en_eff;
    logic [NCH-1:0]  kill;

    hb_pwm_sync #(.W(NPWM), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwm_in),
        .sync_o  (pwm_s)
    );

    hb_demand #(.NCH(NCH), .NPWM(NPWM)) u_demand (
        .drv_en      (drv_en),
        .pwm_s       (pwm_s),
        .ch_fault    (ch_fault),
        .supply_lock (supply_lock),
        .en_eff      (en_eff),
        .kill        (kill)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        hb_channel #(.DEAD_CLKS(DEAD_CLKS)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_eff   (en_eff[i]),
            .cfg_high (drv_cfg[i]),
            .kill     (kill[i]),
            .hs_on    (hs_on[i]),
            .ls_on    (ls_on[i])
        );
    end

    // R9: supply lockout clears every switch on the next clock
    a_r9_lock_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lock |=> (hs_on == '0 && ls_on == '0));

    // R4: channels without a pulse input ignore it
    a_r4_no_pwm_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en[NCH-1:NPWM] == '0) |=> ((hs_on[NCH-1:NPWM] | ls_on[NCH-1:NPWM]) == '0));

endmodule

// File: tb/hb_gate_ctrl_test.sv
module hb_gate_ctrl_test;

    localparam int NCH  = 6;
    localparam int NPWM = 2;
    localparam int DEAD = 8;
    localparam int NVEC = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  drv_en = '0;
    logic [NCH-1:0]  drv_cfg = '0;
    logic [NPWM-1:0] pwm_in = '0;
    logic [NCH-1:0]  ch_fault = '0;
    logic            supply_lock = 1'b0;
    logic [NCH-1:0]  hs_on, ls_on;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    hb_gate_ctrl #(.NCH(NCH), .NPWM(NPWM), .DEAD_CLKS(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_cfg(drv_cfg),
        .pwm_in(pwm_in), .ch_fault(ch_fault), .supply_lock(supply_lock),
        .hs_on(hs_on), .ls_on(ls_on)
    );

    // Vector: en[20:15] cfg[14:9] pwm[8:7] fault[6:1] lock[0]
    localparam logic [20:0] VEC [NVEC] = '{
        {6'h3F, 6'h00, 2'b00, 6'h00, 1'b0},  // R2 all low side
        {6'h3F, 6'h3F, 2'b00, 6'h00, 1'b0},  // R2 all high side
        {6'h15, 6'h2A, 2'b00, 6'h00, 1'b0},  // R2/R11 mixed
        {6'h00, 6'h01, 2'b11, 6'h00, 1'b0},  // R3 pulse enables ch0 high, ch1 low
        {6'h00, 6'h3F, 2'b11, 6'h00, 1'b0},  // R4 ch2..5 ignore pulses
        {6'h00, 6'h01, 2'b01, 6'h00, 1'b0},  // R5 pulse alone drives high side
        {6'h00, 6'h01, 2'b00, 6'h00, 1'b0},  // R5 pulse low, all off
        {6'h3C, 6'h0F, 2'b11, 6'h05, 1'b0},  // R10 faulted channels off
        {6'h3F, 6'h15, 2'b11, 6'h00, 1'b1},  // R9 lockout
        {6'h3F, 6'h15, 2'b11, 6'h00, 1'b0}   // R9 resume
    };

    task automatic tick(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent steady-state model of the requirements
    function automatic logic [11:0] model(logic [5:0] en, logic [5:0] cfg,
                                          logic [1:0] pwm, logic [5:0] flt, logic lk);
        logic [5:0] eff, on;
        eff = en | {4'b0, pwm};
        on  = eff & ~flt & {6{~lk}};
        return {on & cfg, on & ~cfg};
    endfunction

    // Count negedge samples with channel ch fully off, until the expected side is on
    task automatic gap_len(int ch, bit high, output int n);
        n = 0;
        while (!(high ? hs_on[ch] : ls_on[ch]) && n < 40) begin
            if (hs_on[ch] || ls_on[ch]) n = 100;
            n++;
            tick(1);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        tick(3);
        // R1 reset state
        chk("R1 reset hs", 32'(hs_on), 0);
        chk("R1 reset ls", 32'(ls_on), 0);
        rst_n = 1'b1;
        tick(2);

        // R1/R2 first enable from reset turns on after one clock
        drv_en = 6'h04; drv_cfg = 6'h04;
        tick(1);
        chk("R1 first enable hs", 32'(hs_on), 32'h04);
        drv_en = '0; drv_cfg = '0;
        tick(DEAD + 4);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [11:0] exp;
            drv_en      = VEC[v][20:15];
            drv_cfg     = VEC[v][14:9];
            pwm_in      = VEC[v][8:7];
            ch_fault    = VEC[v][6:1];
            supply_lock = VEC[v][0];
            tick(DEAD + 6);
            exp = model(VEC[v][20:15], VEC[v][14:9], VEC[v][8:7], VEC[v][6:1], VEC[v][0]);
            chk($sformatf("R2/R3/R4/R5/R9/R10 vector %0d", v), 32'({hs_on, ls_on}), 32'(exp));
            chk($sformatf("R6 vector %0d overlap", v), 32'(hs_on & ls_on), 0);
        end
        drv_en = '0; drv_cfg = '0; pwm_in = '0; ch_fault = '0; supply_lock = 0;
        tick(DEAD + 4);

        // R7 side change gap length
        drv_en = 6'h08; drv_cfg = 6'h00;
        tick(DEAD + 4);
        chk("R7 start on low", 32'(ls_on[3]), 1);
        drv_cfg = 6'h08;
        tick(1);
        gap_len(3, 1'b1, n);
        chk("R7 changeover gap", 32'(n), DEAD);
        chk("R6 after change", 32'({hs_on[3], ls_on[3]}), 32'b10);

        // R8 off then immediate re-enable of the same side
        drv_en = 6'h00;
        tick(1);
        chk("R11 disable off", 32'({hs_on[3], ls_on[3]}), 0);
        drv_en = 6'h08;
        gap_len(3, 1'b1, n);
        chk("R8 same side re-enable gap", 32'(n), DEAD);

        // R8/R10 side change and fault in the same cycle
        drv_cfg = 6'h00; ch_fault = 6'h08;
        tick(DEAD + 6);
        chk("R10 fault holds off past gap", 32'({hs_on[3], ls_on[3]}), 0);
        ch_fault = 6'h00;
        tick(1);
        chk("R10 resume after fault clear", 32'({hs_on[3], ls_on[3]}), 32'b01);
        drv_en = '0;
        tick(DEAD + 4);

        // R3 pulse latency: off after two clocks, on after the third
        drv_cfg = 6'h01; pwm_in = 2'b01;
        tick(2);
        chk("R3 pulse not yet through", 32'(hs_on[0]), 0);
        tick(1);
        chk("R3 pulse on at third edge", 32'(hs_on[0]), 1);
        chk("R5 low side stays off", 32'(ls_on[0]), 0);
        pwm_in = 2'b00;
        tick(DEAD + 4);

        // R9 lockout and automatic resume
        drv_en = 6'h3F; drv_cfg = 6'h33;
        tick(DEAD + 4);
        supply_lock = 1'b1;
        tick(1);
        chk("R9 lock all off", 32'({hs_on, ls_on}), 0);
        tick(DEAD + 4);
        supply_lock = 1'b0;
        tick(1);
        chk("R9 resume programmed state", 32'({hs_on, ls_on}), 32'({6'h33, 6'h0C}));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule